// File: doc/BRIEF.md
# Vector Modified-Immediate Execute Unit

This unit executes the vector instructions that carry an 8-bit immediate and modify a 128-bit vector register. A 32-bit instruction word arrives with a valid strobe. The unit decodes the word and checks that it belongs to the immediate group. It expands the 8-bit immediate into a 64-bit pattern under control of a 4-bit mode field and an op bit. It then applies a move, inverted move, OR or bit-clear to the destination register and registers the write-back.

The current destination value is fetched through a combinational register-file read port. The read index is driven from the instruction word in the same cycle. One clock later the unit presents the destination index, the 128-bit write-back data, a write enable and an illegal-encoding flag. A 64-bit form writes the result to the low half and clears the upper half.

Top module: `vmi_exec_unit`

## Requirements
- R1: Field positions in the word: destination index = bits 4:0, mode = bits 15:12, op = bit 29, width bit W = bit 30. The immediate is {bits 18:16, bits 9:5}, with bit 18 as immediate bit 7. The registered destination index equals bits 4:0 of the accepted word.
- R2: A valid word belongs to the group only when bit 31 = 0, bits 23:19 = 00000 and bits 11:10 = 01. A valid word that does not belong raises the illegal flag and leaves the write enable low.
- R3: For mode 0xxx with mode bit 0 = 0 and op = 0, each 32-bit lane holds the immediate shifted left by 8 × mode[2:1], and the result is that pattern.
- R4: For modes 1000 and 1010 with op = 0, each 16-bit lane holds the immediate shifted left by 8 × mode[1], and the result is that pattern.
- R5: For mode bit 0 = 1 and mode below 1100, op = 0 gives destination OR pattern, and op = 1 gives destination AND NOT pattern. The pattern is the one from R3 or R4.
- R6: Mode 1100 gives 32-bit lanes of {immediate, 8 ones}, each zero-extended. Mode 1101 gives lanes of {immediate, 16 ones}, each zero-extended. For these two modes, and for mode below 1100 with mode bit 0 = 0, op = 1 writes the bitwise inverse of the pattern.
- R7: Mode 1110 with op = 0 replicates the immediate into all eight bytes. With op = 1, immediate bit i fills byte i with ones or zeros, and no inversion follows.
- R8: Mode 1111 with op = 0 writes into each 32-bit lane the value {a, ~b, b×5, cdefgh, 19 zeros}, where a is immediate bit 7. Mode 1111 with op = 1 and W = 1 writes the 64-bit value {a, ~b, b×8, cdefgh, 48 zeros}.
- R9: Mode 1111 with op = 1 and W = 0 is illegal: the illegal flag rises and no write takes place.
- R10: With W = 0 the result goes to the low 64 bits and the upper 64 bits are written as zero. With W = 1 both halves receive the result.
- R11: All outputs are registered and appear one cycle after the input. Reset clears every output to zero. With no valid strobe, both the write enable and the illegal flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word valid |
| in_insn | input | 32 | Instruction word |
| rf_rd_idx | output | 5 | Register-file read index (combinational from in_insn) |
| rf_rd_data | input | 128 | Current destination value returned by the register file |
| wb_en | output | 1 | Write enable for the write-back |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | 128 | Write-back data |
| wb_illegal | output | 1 | Illegal-encoding flag |

## Verification
The read index is combinational and is due in the cycle the word is presented. Every write-back output is due exactly one rising edge after the word is presented. The bench drives each word on a falling edge and samples all four outputs just after the next rising edge, before the following word is driven. This gives one result per cycle with no pipeline skew to track. The register file is modelled with fixed contents that the unit reads combinationally, so OR and bit-clear results are predictable from the word alone.

// File: rtl/vmi_pkg.sv
package vmi_pkg;
    localparam int INSN_W = 32;
    localparam int REG_W  = 128;
    localparam int HALF_W = 64;
    localparam int IMM_W  = 8;
    localparam int IDX_W  = 5;
    localparam int MODE_W = 4;
    localparam int NHALF  = REG_W / HALF_W;
    localparam int NBYTE  = HALF_W / IMM_W;

    typedef enum logic [1:0] {
        ALU_MOV = 2'd0,
        ALU_ORR = 2'd1,
        ALU_BIC = 2'd2
    } alu_op_e;

    typedef struct packed {
        logic [IDX_W-1:0]  rd;
        logic [MODE_W-1:0] mode;
        logic              op;
        logic              wide;
        logic [IMM_W-1:0]  imm;
        logic              match;
    } fields_t;

    typedef struct packed {
        logic              en;
        logic              illegal;
        logic [IDX_W-1:0]  idx;
        logic [REG_W-1:0]  data;
    } wb_t;

    function automatic logic [HALF_W-1:0] rep32(input logic [31:0] lane);
        return {lane, lane};
    endfunction

    function automatic logic [HALF_W-1:0] rep16(input logic [15:0] lane);
        return {lane, lane, lane, lane};
    endfunction
endpackage

// File: rtl/vmi_decode.sv
module vmi_decode
    import vmi_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output fields_t           fld
);
    logic unused_bits;
    assign unused_bits = ^insn[28:24];

    always_comb begin
        fld.rd    = insn[4:0];
        fld.mode  = insn[15:12];
        fld.op    = insn[29];
        fld.wide  = insn[30];
        fld.imm   = {insn[18:16], insn[9:5]};
        fld.match = !insn[31] && (insn[23:19] == 5'b0) && (insn[11:10] == 2'b01);
    end
endmodule

// File: rtl/vmi_expand.sv
module vmi_expand
    import vmi_pkg::*;
(
    input  fields_t           fld,
    output logic [HALF_W-1:0] pattern,
    output alu_op_e           alu_op,
    output logic              bad
);
    logic [HALF_W-1:0] bytemask;
    logic [HALF_W-1:0] raw;
    logic [31:0]       single;
    logic [HALF_W-1:0] dbl;
    logic              inv;
    logic a, b;

    for (genvar g = 0; g < NBYTE; g++) begin : g_bytemask
        assign bytemask[g*IMM_W +: IMM_W] = {IMM_W{fld.imm[g]}};
    end

    assign a      = fld.imm[7];
    assign b      = fld.imm[6];
    assign single = {a, ~b, {5{b}}, fld.imm[5:0], 19'b0};
    assign dbl    = {a, ~b, {8{b}}, fld.imm[5:0], 48'b0};

    always_comb begin
        raw    = '0;
        inv    = 1'b0;
        bad    = 1'b0;
        alu_op = ALU_MOV;
        case (fld.mode[3:1])
            3'd0, 3'd1, 3'd2, 3'd3: begin
                raw = rep32(32'(fld.imm) << {fld.mode[2:1], 3'b000});
                if (fld.mode[0]) alu_op = fld.op ? ALU_BIC : ALU_ORR;
                else             inv    = fld.op;
            end
            3'd4, 3'd5: begin
                raw = rep16(16'(fld.imm) << {fld.mode[1], 3'b000});
                if (fld.mode[0]) alu_op = fld.op ? ALU_BIC : ALU_ORR;
                else             inv    = fld.op;
            end
            3'd6: begin
                raw = fld.mode[0] ? rep32({8'b0, fld.imm, 16'hffff})
                                  : rep32({16'b0, fld.imm, 8'hff});
                inv = fld.op;
            end
            default: begin
                if (!fld.mode[0]) begin
                    raw = fld.op ? bytemask : {NBYTE{fld.imm}};
                end else begin
                    raw = fld.op ? dbl : rep32(single);
                    bad = fld.op && !fld.wide;
                end
            end
        endcase
        pattern = inv ? ~raw : raw;
    end
endmodule

// File: rtl/vmi_alu.sv
module vmi_alu
    import vmi_pkg::*;
(
    input  logic [REG_W-1:0]  dst,
    input  logic [HALF_W-1:0] pattern,
    input  alu_op_e           alu_op,
    input  logic              wide,
    output logic [REG_W-1:0]  result
);
    for (genvar h = 0; h < NHALF; h++) begin : g_half
        logic [HALF_W-1:0] cur;
        logic [HALF_W-1:0] nxt;
        assign cur = dst[h*HALF_W +: HALF_W];
        always_comb begin
            case (alu_op)
                ALU_ORR: nxt = cur | pattern;
                ALU_BIC: nxt = cur & ~pattern;
                default: nxt = pattern;
            endcase
            if (h != 0 && !wide) nxt = '0;
        end
        assign result[h*HALF_W +: HALF_W] = nxt;
    end
endmodule

// File: rtl/vmi_exec_unit.sv
module vmi_exec_unit
    import vmi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] in_insn,
    output logic [IDX_W-1:0]  rf_rd_idx,
    input  logic [REG_W-1:0]  rf_rd_data,
    output logic              wb_en,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [REG_W-1:0]  wb_data,
    output logic              wb_illegal
);
    fields_t           fld;
    logic [HALF_W-1:0] pattern;
    alu_op_e           alu_op;
    logic              bad;
    logic [REG_W-1:0]  result;
    wb_t               wb_q;

    vmi_decode u_dec (.insn(in_insn), .fld(fld));
    vmi_expand u_exp (.fld(fld), .pattern(pattern), .alu_op(alu_op), .bad(bad));
    vmi_alu    u_alu (.dst(rf_rd_data), .pattern(pattern), .alu_op(alu_op),
                      .wide(fld.wide), .result(result));

    assign rf_rd_idx = fld.rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_q <= '0;
        end else begin
            wb_q.en      <= in_valid && fld.match && !bad;
            wb_q.illegal <= in_valid && (!fld.match || bad);
            if (in_valid) begin
                wb_q.idx  <= fld.rd;
                wb_q.data <= result;
            end
        end
    end

    assign wb_en      = wb_q.en;
    assign wb_illegal = wb_q.illegal;
    assign wb_idx     = wb_q.idx;
    assign wb_data    = wb_q.data;

    a_r11_en_needs_valid: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> $past(in_valid));
    a_r2_no_write_when_illegal: assert property (@(posedge clk) disable iff (rst)
        !(wb_en && wb_illegal));
    a_r1_index_follows_word: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (wb_idx == $past(in_insn[4:0])));
    a_r2_mismatch_flags: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_insn[31] || in_insn[23:19] != 5'b0 || in_insn[11:10] != 2'b01))
        |=> (wb_illegal && !wb_en));
    a_r9_double_narrow_illegal: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fld.match && in_insn[15:12] == 4'hf && in_insn[29] && !in_insn[30])
        |=> wb_illegal);
    a_r10_upper_cleared: assert property (@(posedge clk) disable iff (rst)
        (wb_en && !$past(in_insn[30])) |-> (wb_data[127:64] == 64'b0));
endmodule

// File: tb/sim_vmi_exec_unit.sv
module sim_vmi_exec_unit;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [31:0]  in_insn;
    logic [4:0]   rf_rd_idx;
    logic [127:0] rf_rd_data;
    logic         wb_en;
    logic [4:0]   wb_idx;
    logic [127:0] wb_data;
    logic         wb_illegal;

    logic [127:0] rf [32];
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    assign rf_rd_data = rf[rf_rd_idx];

    vmi_exec_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn),
        .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data), .wb_illegal(wb_illegal)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit q, input bit op, input logic [3:0] mode,
                                       input logic [7:0] imm, input logic [4:0] rd);
        return {1'b0, q, op, 5'b01111, 5'b00000, imm[7:5], mode, 2'b01, imm[4:0], rd};
    endfunction

    function automatic logic [63:0] pat_of(input logic [3:0] mode, input bit op,
                                           input logic [7:0] imm);
        logic [63:0] p = '0;
        logic [7:0] a = {7'b0, imm[7]};
        logic [7:0] b = {7'b0, imm[6]};
        for (int k = 0; k < 8; k++) begin
            logic [7:0] v = 8'h00;
            if (mode < 4'd8) v = ((k % 4) == int'(mode[2:1])) ? imm : 8'h00;
            else if (mode < 4'd12) v = ((k % 2) == int'(mode[1])) ? imm : 8'h00;
            else if (mode == 4'd12) v = (k % 4 == 0) ? 8'hff : (k % 4 == 1) ? imm : 8'h00;
            else if (mode == 4'd13) v = (k % 4 < 2) ? 8'hff : (k % 4 == 2) ? imm : 8'h00;
            else if (mode == 4'd14) v = op ? (imm[k] ? 8'hff : 8'h00) : imm;
            p[k*8 +: 8] = v;
        end
        if (mode == 4'd15) begin
            logic [31:0] s;
            s = (32'(a) << 31) | (32'(b ^ 8'd1) << 30) | ({32{b[0]}} & 32'h3e00_0000)
                | (32'(imm[5:0]) << 19);
            p = op ? ((64'(a) << 63) | (64'(b ^ 8'd1) << 62) | ({64{b[0]}} & 64'h3fc0_0000_0000_0000)
                      | (64'(imm[5:0]) << 48))
                   : {s, s};
        end
        if (op && (mode < 4'd12 && !mode[0] || mode == 4'd12 || mode == 4'd13)) p = ~p;
        return p;
    endfunction

    function automatic string tag_of(input logic [3:0] mode, input bit op);
        if (mode == 4'd15) return "R8";
        if (mode == 4'd14) return "R7";
        if (mode >= 4'd12) return "R6";
        if (mode[0]) return "R5";
        if (op) return "R6";
        return (mode < 4'd8) ? "R3" : "R4";
    endfunction

    task automatic apply(input bit v, input logic [31:0] w);
        logic match, bad, e_en, e_ill;
        logic [3:0] mode;
        bit op, q;
        logic [7:0] imm;
        logic [63:0] p, lo, hi;
        logic [127:0] d;
        string t;
        @(negedge clk);
        in_valid = v;
        in_insn = w;
        mode = w[15:12]; op = w[29]; q = w[30];
        imm = {w[18:16], w[9:5]};
        d = rf[w[4:0]];
        match = (w[31] == 1'b0) && (w[23:19] == 5'd0) && (w[11:10] == 2'b01);
        bad = (mode == 4'd15) && op && !q;
        e_en = v && match && !bad;
        e_ill = v && !(match && !bad);
        p = pat_of(mode, op, imm);
        t = tag_of(mode, op);
        if (mode < 4'd12 && mode[0]) begin
            lo = op ? (d[63:0] & ~p) : (d[63:0] | p);
            hi = op ? (d[127:64] & ~p) : (d[127:64] | p);
        end else begin
            lo = p; hi = p;
        end
        #1;
        chk("R1 read index", 128'(rf_rd_idx), 128'(w[4:0]));
        @(posedge clk);
        #1;
        chk(v ? (match ? (bad ? "R9 enable" : "R11 enable") : "R2 enable") : "R11 idle enable",
            128'(wb_en), 128'(e_en));
        chk(v ? (match ? (bad ? "R9 illegal" : "R11 illegal") : "R2 illegal") : "R11 idle illegal",
            128'(wb_illegal), 128'(e_ill));
        if (e_en) begin
            chk("R1 index", 128'(wb_idx), 128'(w[4:0]));
            chk(t, 128'(wb_data[63:0]), 128'(lo));
            if (q) chk(t, 128'(wb_data[127:64]), 128'(hi));
            else   chk("R10 upper zero", 128'(wb_data[127:64]), 128'(0));
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        for (int i = 0; i < 32; i++)
            rf[i] = {$urandom, $urandom, $urandom, $urandom};
        rst = 1'b1; in_valid = 1'b0; in_insn = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R11 reset enable", 128'(wb_en), 128'(0));
        chk("R11 reset illegal", 128'(wb_illegal), 128'(0));
        chk("R11 reset data", wb_data, 128'(0));
        chk("R11 reset index", 128'(wb_idx), 128'(0));
        @(negedge clk);
        rst = 1'b0;

        for (int m = 0; m < 16; m++)
            for (int o = 0; o < 2; o++)
                for (int qq = 0; qq < 2; qq++) begin
                    apply(1'b1, mk(qq[0], o[0], m[3:0], 8'hc5, 5'(m + 3)));
                    apply(1'b1, mk(qq[0], o[0], m[3:0], 8'h3a, 5'(31 - m)));
                end
        apply(1'b1, mk(1'b0, 1'b1, 4'hf, 8'hff, 5'd7));
        apply(1'b1, mk(1'b1, 1'b1, 4'hf, 8'h00, 5'd7));
        apply(1'b1, mk(1'b1, 1'b0, 4'h0, 8'hff, 5'd0) | 32'h8000_0000);
        apply(1'b1, mk(1'b1, 1'b0, 4'h0, 8'hff, 5'd1) | 32'h0008_0000);
        apply(1'b1, mk(1'b1, 1'b0, 4'h0, 8'hff, 5'd2) | 32'h0080_0000);
        apply(1'b1, mk(1'b1, 1'b0, 4'h0, 8'hff, 5'd3) ^ 32'h0000_0c00);
        apply(1'b1, mk(1'b1, 1'b0, 4'h0, 8'hff, 5'd4) ^ 32'h0000_0400);
        apply(1'b0, mk(1'b1, 1'b0, 4'he, 8'h81, 5'd9));
        apply(1'b0, mk(1'b1, 1'b0, 4'h0, 8'h81, 5'd9) | 32'h8000_0000);
        apply(1'b1, mk(1'b0, 1'b1, 4'he, 8'h81, 5'd9));

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] w;
            logic [31:0] r = $urandom;
            w = mk(r[0], r[1], r[5:2], r[13:6], r[18:14]);
            if (r[21:19] == 3'd0) w[31] = 1'b1;
            if (r[21:19] == 3'd1) w[23:19] = r[26:22] | 5'd1;
            if (r[21:19] == 3'd2) w[11:10] = r[24] ? 2'b11 : 2'b00;
            apply(r[31:28] != 4'd0, w);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule